// File: doc/BRIEF.md
# Descriptor Task Queue Sequencer

This block runs a chain of scaling jobs without software stepping through each one. Software writes the memory address of a job's descriptor list into a four-entry queue. The sequencer takes jobs from the queue strictly in the order they were written. For each job it reads the descriptor list from memory one 32-bit word at a time. It decodes each word by the two-bit command type in its lowest bits and forwards register-write and engine-start commands to the processing engine. After an engine start, it waits for the engine to report completion before reading further.

A descriptor list may branch once into a sub-list. When the sub-list ends, reading resumes at the word after the branch. A job counts as complete only when the end of its top-level list is reached. At that point its queue slot is released and the next job begins.

Software keeps the queue topped up using the fill level and two pulses: one when the queue drains and one when a full queue gains a free slot. A write that arrives while the queue is full is dropped and recorded in a sticky flag. A byte-swap input lets descriptor memory be kept in either byte order.

Top module: `desc_task_seq`

## Requirements
- R1: The queue holds four job addresses and `fill_level` reports how many it holds. The running job keeps its slot until it completes. A write while `fill_level` is 4 is discarded and sets `ovf_flag`, which stays set until reset.
- R2: Jobs run in write order. No descriptor read of a job is issued before the top-level end word of the previous job has been read.
- R3: When `swap_en` is 1, each fetched word has its four bytes reversed before decoding. Byte 0 (bits [7:0]) becomes bits [31:24].
- R4: A word with type bits [1:0] = 00 is a register write. Its target index is bits [9:2], and its data is the next word in the list. The sequencer emits one command with `cmd_kind` = 0, that index and that data.
- R5: A word with type 01 is a branch. Reading continues at the address held in bits [31:2] with bits [1:0] forced to zero. An end word inside the sub-list resumes reading at the word after the branch.
- R6: A type-01 word read inside a sub-list is an error. `irq_error` pulses for one cycle, the job is abandoned with no further commands and its slot is released, and the next job proceeds.
- R7: A word with type 10 emits one command with `cmd_kind` = 1. No further memory read is issued until `eng_done` is seen.
- R8: A word with type 11 at the top level completes the job. If that completion leaves the queue empty, `irq_drained` pulses for one cycle.
- R9: `irq_free_slot` pulses for one cycle when a job completes while the queue held four entries.
- R10: At most one read is outstanding. `mem_req` is a one-cycle pulse that is not raised again until `mem_rvalid` has returned. Consecutive words are read at addresses 4 apart.
- R11: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_kind`, `cmd_index` and `cmd_data` hold their values.
- R12: A synchronous reset empties the queue, abandons any job and clears `ovf_flag` and all interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| swap_en | input | 1 | Reverse byte order of fetched words |
| wr_en | input | 1 | Enqueue `wr_addr` as a new job |
| wr_addr | input | AW | Job descriptor list address |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | AW | Read word address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data word |
| cmd_valid | output | 1 | Command offered to engine |
| cmd_ready | input | 1 | Engine accepts command |
| cmd_kind | output | 1 | 0 register write, 1 engine start |
| cmd_index | output | IDX_W | Register index of a write |
| cmd_data | output | 32 | Register data of a write |
| eng_done | input | 1 | Engine finished the started run |
| fill_level | output | CNT_W | Entries in the queue |
| ovf_flag | output | 1 | Sticky dropped-write flag |
| irq_drained | output | 1 | Pulse: last queued job completed |
| irq_free_slot | output | 1 | Pulse: full queue released a slot |
| irq_error | output | 1 | Pulse: nested branch aborted a job |

## Verification
The hardest state to reach from the ports is a full queue taking a fifth write while the first job is still running. The bench reaches it by slowing the engine model, so that completion arrives some thirty cycles after a start. It then writes five addresses on back-to-back cycles. That same run confirms that the slot-free pulse occurs exactly once and that the dropped job's list is never read. The nested-branch abort is reached by a sub-list whose first word is itself a branch, followed by a healthy job that must still run.

// File: rtl/desc_seq_pkg.sv
package desc_seq_pkg;

    // Descriptor command type carried in bits [1:0] of each word.
    typedef enum logic [1:0] {
        OP_REGWR = 2'b00,
        OP_LINK  = 2'b01,
        OP_START = 2'b10,
        OP_END   = 2'b11
    } desc_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_WAIT,
        S_EXEC,
        S_CMD,
        S_ENG,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/task_fifo.sv
module task_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } fq_t;

    fq_t q_q, q_d;
    logic [W-1:0] slots [DEPTH];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        q_d = q_q;
        if (push) q_d.wr = step(q_q.wr);
        if (pop)  q_d.rd = step(q_q.rd);
        q_d.cnt = q_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) q_q <= '0;
        else     q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (push) slots[q_q.wr] <= din;
    end

    assign head  = slots[q_q.rd];
    assign count = q_q.cnt;
    assign full  = (q_q.cnt == CW'(DEPTH));
    assign empty = (q_q.cnt == '0);

endmodule

// File: rtl/desc_word_dec.sv
module desc_word_dec
    import desc_seq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 8,
    localparam int WW   = 32,
    localparam int NB   = WW / 8
) (
    input  logic [WW-1:0]    raw,
    input  logic             swap,
    output logic [WW-1:0]    word,
    output desc_op_e         op,
    output logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    link
);

    logic [WW-1:0] rev;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign rev[8*b +: 8] = raw[8*(NB-1-b) +: 8];
    end

    assign word = swap ? rev : raw;
    assign op   = desc_op_e'(word[1:0]);
    assign idx  = word[IDX_W+1:2];
    assign link = {word[AW-1:2], 2'b00};

endmodule

// File: rtl/desc_task_seq.sv
module desc_task_seq
    import desc_seq_pkg::*;
#(
    parameter int QDEPTH = 4,
    parameter int AW     = 32,
    parameter int IDX_W  = 8,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             swap_en,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic             cmd_kind,
    output logic [IDX_W-1:0] cmd_index,
    output logic [31:0]      cmd_data,
    input  logic             eng_done,
    output logic [CNT_W-1:0] fill_level,
    output logic             ovf_flag,
    output logic             irq_drained,
    output logic             irq_free_slot,
    output logic             irq_error
);

    localparam logic [AW-1:0] STEP = AW'(4);

    typedef struct packed {
        seq_state_e       st;
        logic [AW-1:0]    addr;
        logic [AW-1:0]    ret;
        logic             depth;
        logic             data_ph;
        desc_op_e         op;
        logic [IDX_W-1:0] idx;
        logic [AW-1:0]    link;
        logic             ckind;
        logic [IDX_W-1:0] cidx;
        logic [31:0]      cdata;
        logic             ovf;
        logic             irq_drn;
        logic             irq_free;
        logic             irq_err;
    } seq_t;

    seq_t q_q, q_d;

    logic             push, pop, q_full, q_empty;
    logic [AW-1:0]    q_head;
    logic [CNT_W-1:0] q_count;
    logic [31:0]      dec_word;
    desc_op_e         dec_op;
    logic [IDX_W-1:0] dec_idx;
    logic [AW-1:0]    dec_link;

    task_fifo #(.DEPTH(QDEPTH), .W(AW)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .din   (wr_addr),
        .head  (q_head),
        .count (q_count),
        .full  (q_full),
        .empty (q_empty)
    );

    desc_word_dec #(.AW(AW), .IDX_W(IDX_W)) u_dec (
        .raw  (mem_rdata),
        .swap (swap_en),
        .word (dec_word),
        .op   (dec_op),
        .idx  (dec_idx),
        .link (dec_link)
    );

    // Writes to a full queue are dropped, even when a slot frees this cycle.
    assign push = wr_en && !q_full;

    always_comb begin
        q_d          = q_q;
        q_d.irq_drn  = 1'b0;
        q_d.irq_free = 1'b0;
        q_d.irq_err  = 1'b0;
        pop          = 1'b0;
        if (wr_en && q_full) q_d.ovf = 1'b1;

        case (q_q.st)
            S_IDLE: begin
                if (!q_empty) begin
                    q_d.addr  = q_head;
                    q_d.depth = 1'b0;
                    q_d.st    = S_REQ;
                end
            end
            S_REQ: q_d.st = S_WAIT;
            S_WAIT: begin
                if (mem_rvalid) begin
                    if (q_q.data_ph) begin
                        q_d.data_ph = 1'b0;
                        q_d.ckind   = 1'b0;
                        q_d.cdata   = dec_word;
                        q_d.st      = S_CMD;
                    end else begin
                        q_d.op   = dec_op;
                        q_d.idx  = dec_idx;
                        q_d.link = dec_link;
                        q_d.st   = S_EXEC;
                    end
                end
            end
            S_EXEC: begin
                case (q_q.op)
                    OP_REGWR: begin
                        q_d.cidx    = q_q.idx;
                        q_d.data_ph = 1'b1;
                        q_d.addr    = q_q.addr + STEP;
                        q_d.st      = S_REQ;
                    end
                    OP_LINK: begin
                        if (q_q.depth) begin
                            q_d.irq_err = 1'b1;
                            q_d.st      = S_DONE;
                        end else begin
                            q_d.ret   = q_q.addr + STEP;
                            q_d.depth = 1'b1;
                            q_d.addr  = q_q.link;
                            q_d.st    = S_REQ;
                        end
                    end
                    OP_START: begin
                        q_d.ckind = 1'b1;
                        q_d.cidx  = '0;
                        q_d.cdata = '0;
                        q_d.st    = S_CMD;
                    end
                    default: begin
                        if (q_q.depth) begin
                            q_d.depth = 1'b0;
                            q_d.addr  = q_q.ret;
                            q_d.st    = S_REQ;
                        end else begin
                            q_d.st = S_DONE;
                        end
                    end
                endcase
            end
            S_CMD: begin
                if (cmd_ready) begin
                    if (q_q.ckind) begin
                        q_d.st = S_ENG;
                    end else begin
                        q_d.addr = q_q.addr + STEP;
                        q_d.st   = S_REQ;
                    end
                end
            end
            S_ENG: begin
                if (eng_done) begin
                    q_d.addr = q_q.addr + STEP;
                    q_d.st   = S_REQ;
                end
            end
            S_DONE: begin
                pop          = 1'b1;
                q_d.depth    = 1'b0;
                q_d.data_ph  = 1'b0;
                q_d.irq_drn  = (q_count == CNT_W'(1)) && !push;
                q_d.irq_free = q_full;
                q_d.st       = S_IDLE;
            end
            default: q_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q_q <= '0;
        else     q_q <= q_d;
    end

    assign mem_req       = (q_q.st == S_REQ);
    assign mem_addr      = q_q.addr;
    assign cmd_valid     = (q_q.st == S_CMD);
    assign cmd_kind      = q_q.ckind;
    assign cmd_index     = q_q.cidx;
    assign cmd_data      = q_q.cdata;
    assign fill_level    = q_count;
    assign ovf_flag      = q_q.ovf;
    assign irq_drained   = q_q.irq_drn;
    assign irq_free_slot = q_q.irq_free;
    assign irq_error     = q_q.irq_err;

endmodule

// File: rtl/desc_seq_chk.sv
module desc_seq_chk #(
    parameter int QDEPTH = 4,
    parameter int IDX_W  = 8,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             mem_req,
    input logic             mem_rvalid,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             cmd_kind,
    input logic [IDX_W-1:0] cmd_index,
    input logic [31:0]      cmd_data,
    input logic             eng_done,
    input logic [CNT_W-1:0] fill_level,
    input logic             ovf_flag,
    input logic             irq_drained,
    input logic             irq_error
);

    logic rd_open_q;
    logic eng_busy_q;

    always_ff @(posedge clk) begin
        if (rst)             rd_open_q <= 1'b0;
        else if (mem_req)    rd_open_q <= 1'b1;
        else if (mem_rvalid) rd_open_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                                  eng_busy_q <= 1'b0;
        else if (cmd_valid && cmd_ready && cmd_kind) eng_busy_q <= 1'b1;
        else if (eng_done)                        eng_busy_q <= 1'b0;
    end

    assert_fill_bound_R1: assert property (@(posedge clk) disable iff (rst)
        fill_level <= CNT_W'(QDEPTH));

    assert_ovf_sets_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fill_level == CNT_W'(QDEPTH)) |=> ovf_flag);

    assert_ovf_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    assert_error_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        irq_error |=> !irq_error);

    assert_engine_wait_R7: assert property (@(posedge clk) disable iff (rst)
        eng_busy_q |-> !mem_req);

    assert_drain_empty_R8: assert property (@(posedge clk) disable iff (rst)
        irq_drained |-> (fill_level == '0));

    assert_one_read_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !rd_open_q);

    assert_req_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind)
                                       && $stable(cmd_index) && $stable(cmd_data)));

    assert_reset_clear_R12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fill_level == '0 && !ovf_flag && !irq_drained && !irq_error));

endmodule

bind desc_task_seq desc_seq_chk #(.QDEPTH(QDEPTH), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_kind   (cmd_kind),
    .cmd_index  (cmd_index),
    .cmd_data   (cmd_data),
    .eng_done   (eng_done),
    .fill_level (fill_level),
    .ovf_flag   (ovf_flag),
    .irq_drained(irq_drained),
    .irq_error  (irq_error)
);

// File: tb/sim_desc_task_seq.sv
`timescale 1ns/1ps
module sim_desc_task_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        swap_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_addr = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic        cmd_kind;
    logic [7:0]  cmd_index;
    logic [31:0] cmd_data;
    logic        eng_done = 1'b0;
    logic [2:0]  fill_level;
    logic        ovf_flag, irq_drained, irq_free_slot, irq_error;

    always #2 clk = ~clk;

    desc_task_seq u0 (.*);

    // memory model: one-cycle read latency
    logic [31:0] mem [0:1023];
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem[mem_addr[11:2]];
    end

    // engine model and ready pattern
    int eng_cnt = 0, eng_delay = 3, cyc = 0;
    logic rdy_alt = 1'b0;
    always @(negedge clk) begin
        cyc++;
        cmd_ready = rdy_alt ? cyc[0] : 1'b1;
        eng_done  = 1'b0;
        if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) eng_done = 1'b1;
        end
        if (cmd_valid && cmd_ready && cmd_kind) eng_cnt = eng_delay;
    end

    // monitor
    logic        log_clr = 1'b0;
    int          n_addr = 0, n_cmd = 0, c_drn = 0, c_free = 0, c_err = 0;
    logic [31:0] addr_log [0:63];
    logic [40:0] cmd_log  [0:63];
    always @(posedge clk) begin
        if (log_clr) begin
            n_addr = 0; n_cmd = 0; c_drn = 0; c_free = 0; c_err = 0;
        end else begin
            if (mem_req && n_addr < 64) begin addr_log[n_addr] = mem_addr; n_addr++; end
            if (cmd_valid && cmd_ready && n_cmd < 64) begin
                cmd_log[n_cmd] = {cmd_kind, cmd_index, cmd_data}; n_cmd++;
            end
            if (irq_drained)   c_drn++;
            if (irq_free_slot) c_free++;
            if (irq_error)     c_err++;
        end
    end

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        log_clr = 1'b1; @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic put_job(input logic [31:0] a);
        wr_en = 1'b1; wr_addr = a; @(negedge clk); wr_en = 1'b0;
    endtask

    function automatic logic [40:0] cw(input logic k, input logic [7:0] i, input logic [31:0] d);
        return {k, i, d};
    endfunction

    task automatic t_reset();
        check("R12 fill after reset", fill_level, 0);
        check("R12 ovf after reset", ovf_flag, 0);
        check("R12 no request after reset", mem_req, 0);
        check("R12 no command after reset", cmd_valid, 0);
    endtask

    // R4 R7 R10 R11: register write then engine start, ready toggling
    task automatic t_basic();
        logic [31:0] ea [4] = '{32'h100, 32'h104, 32'h108, 32'h10C};
        mem[32'h100>>2] = 32'h14; mem[32'h104>>2] = 32'hDEADBEEF;
        mem[32'h108>>2] = 32'h2;  mem[32'h10C>>2] = 32'h3;
        rdy_alt = 1'b1; clear_logs(); put_job(32'h100);
        repeat (80) @(negedge clk);
        rdy_alt = 1'b0;
        check("R10 basic read count", n_addr, 4);
        for (int i = 0; i < 4; i++) check("R10 basic read address", addr_log[i], ea[i]);
        check("R4 basic cmd count", n_cmd, 2);
        check("R4 register write cmd", cmd_log[0], cw(0, 8'd5, 32'hDEADBEEF));
        check("R7 engine start cmd", cmd_log[1], cw(1, 8'd0, 32'h0));
        check("R8 basic drained pulse", c_drn, 1);
    endtask

    // R5: branch into sub-list and return
    task automatic t_link();
        logic [31:0] ea [9] = '{32'h300, 32'h304, 32'h308, 32'h400, 32'h404,
                                32'h408, 32'h30C, 32'h310, 32'h314};
        mem[32'h300>>2] = 32'h04;  mem[32'h304>>2] = 32'h11; mem[32'h308>>2] = 32'h401;
        mem[32'h30C>>2] = 32'h08;  mem[32'h310>>2] = 32'h22; mem[32'h314>>2] = 32'h3;
        mem[32'h400>>2] = 32'h0C;  mem[32'h404>>2] = 32'h33; mem[32'h408>>2] = 32'h3;
        clear_logs(); put_job(32'h300);
        repeat (80) @(negedge clk);
        check("R5 link read count", n_addr, 9);
        for (int i = 0; i < 9; i++) check("R5 link read address", addr_log[i], ea[i]);
        check("R5 link cmd count", n_cmd, 3);
        check("R5 cmd before link", cmd_log[0], cw(0, 8'd1, 32'h11));
        check("R5 cmd in sub-list", cmd_log[1], cw(0, 8'd3, 32'h33));
        check("R5 cmd after return", cmd_log[2], cw(0, 8'd2, 32'h22));
        check("R8 link drained pulse", c_drn, 1);
    endtask

    // R6: nested branch aborts, next job runs
    task automatic t_nested();
        logic [31:0] ea [5] = '{32'h500, 32'h600, 32'h800, 32'h804, 32'h808};
        mem[32'h500>>2] = 32'h601; mem[32'h504>>2] = 32'h24; mem[32'h508>>2] = 32'h9;
        mem[32'h50C>>2] = 32'h3;   mem[32'h600>>2] = 32'h701; mem[32'h700>>2] = 32'h28;
        mem[32'h800>>2] = 32'h10;  mem[32'h804>>2] = 32'h4;  mem[32'h808>>2] = 32'h3;
        clear_logs(); put_job(32'h500); put_job(32'h800);
        repeat (80) @(negedge clk);
        check("R6 error pulse count", c_err, 1);
        check("R6 read count", n_addr, 5);
        for (int i = 0; i < 5; i++) check("R6 read address", addr_log[i], ea[i]);
        check("R6 cmd count", n_cmd, 1);
        check("R6 next job cmd", cmd_log[0], cw(0, 8'd4, 32'h4));
        check("R8 drained once after two jobs", c_drn, 1);
    endtask

    // R1 R2 R9: overflow while first job waits on a slow engine
    task automatic t_order_ovf();
        logic [31:0] ea [7] = '{32'h900, 32'h904, 32'hA00, 32'hA04, 32'hA08, 32'hB00, 32'hC00};
        mem[32'h900>>2] = 32'h2;  mem[32'h904>>2] = 32'h3;
        mem[32'hA00>>2] = 32'h18; mem[32'hA04>>2] = 32'h66; mem[32'hA08>>2] = 32'h3;
        mem[32'hB00>>2] = 32'h3;  mem[32'hC00>>2] = 32'h3;  mem[32'hD00>>2] = 32'h2;
        eng_delay = 30; clear_logs();
        put_job(32'h900); put_job(32'hA00); put_job(32'hB00); put_job(32'hC00); put_job(32'hD00);
        @(negedge clk);
        check("R1 fill at four", fill_level, 4);
        check("R1 overflow flagged", ovf_flag, 1);
        repeat (200) @(negedge clk);
        eng_delay = 3;
        check("R2 read count", n_addr, 7);
        for (int i = 0; i < 7; i++) check("R2 read order", addr_log[i], ea[i]);
        check("R2 cmd count", n_cmd, 2);
        check("R2 first job cmd", cmd_log[0], cw(1, 8'd0, 32'h0));
        check("R2 second job cmd", cmd_log[1], cw(0, 8'd6, 32'h66));
        check("R9 free-slot pulse count", c_free, 1);
        check("R8 drained pulse", c_drn, 1);
        check("R1 fill empty after drain", fill_level, 0);
        check("R1 overflow sticky", ovf_flag, 1);
    endtask

    // R3: byte-reversed descriptors
    task automatic t_swap();
        mem[32'hE00>>2] = 32'h1C000000; mem[32'hE04>>2] = 32'h78563412;
        mem[32'hE08>>2] = 32'h03000000;
        swap_en = 1'b1; clear_logs(); put_job(32'hE00);
        repeat (60) @(negedge clk);
        swap_en = 1'b0;
        check("R3 swap cmd count", n_cmd, 1);
        check("R3 swapped register write", cmd_log[0], cw(0, 8'd7, 32'h12345678));
        check("R3 swap read count", n_addr, 3);
    endtask

    task automatic t_reset_clears();
        rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0; @(negedge clk);
        check("R12 ovf cleared by reset", ovf_flag, 0);
        check("R12 fill cleared by reset", fill_level, 0);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_link();
        t_nested();
        t_order_ovf();
        t_swap();
        t_reset_clears();
        finished = 1;
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
            $finish;
        end
    end

endmodule